// File: doc/BRIEF.md
# Single-Clock Queue Buffer with Wrap-Tracked Status

This block is a first-in first-out store for one clock domain. A producer offers a word on `wr_data` and raises `wr_en`; the word is kept on that rising edge unless the store is already full. A consumer raises `rd_en` to pull the oldest stored word onto the registered output `rd_data`. The word may be sampled there in the following cycle. The width of a word and the number of entries are parameters, and the entry count need not be a power of two.

The read and write indices run only over 0 to DEPTH-1 and have no extra pointer bit. A one-bit wrap flag beside them tells the two equal-index states apart. The flag is set when the write index rolls over from the last entry back to 0. It is cleared when the read index does the same. Equal indices with the flag set mean full. Equal indices with the flag clear mean empty. A write request against a full store and a read request against an empty one are dropped without any other effect.

Top module: `sync_fifo_wrap`

## Requirements
- R1: Words appear on `rd_data` in exactly the order in which they were accepted.
- R2: On every rising edge where `wr_en` is high and `full` is low, the word on `wr_data` is stored. Holding `wr_en` high stores one new word per cycle.
- R3: While `full` is high, a write request without a read is ignored: `full` stays high, and no word offered in that cycle ever reaches `rd_data`.
- R4: After reset `empty` is 1, `full` is 0 and `rd_data` is 0. `empty` falls after the edge that stores the first word.
- R5: A write alone never changes `rd_data`. The output changes only on an edge where a read is accepted.
- R6: When `rd_en` is high and `empty` is low on a rising edge, the oldest stored word is on `rd_data` after that edge.
- R7: `empty` rises after the edge that performs the read removing the last stored word.
- R8: `full` is high exactly when DEPTH words are held, and `full` and `empty` are never high together.
- R9: When the store is full and both `rd_en` and `wr_en` are high on one edge, the read is performed and the write is rejected. The count drops to DEPTH-1.
- R10: Both indices advance modulo DEPTH. Set-up and clearing of the wrap flag keep the status correct across any number of roll-overs, including for a DEPTH that is not a power of two (default 5).
- R11: A read request while `empty` is high is ignored, and `rd_data` keeps its previous value.
- R12: When the store is neither full nor empty, a simultaneous read and write both take effect and the count of held words does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request for the word on `wr_data` |
| wr_data | input | DATA_W | Word to be stored |
| rd_en | input | 1 | Read request for the oldest word |
| rd_data | output | DATA_W | Registered output word |
| full | output | 1 | All DEPTH entries are occupied |
| empty | output | 1 | No entry is occupied |

## Verification
A read and a write can fall on the same edge. The bench forces this in three states: with the store empty, where only the write takes effect; part-filled, where both take effect; and full, where only the read takes effect. It also runs long stretches of random requests that make both indices roll over many times. A scoreboard queue models acceptance from its own count of held words. Each popped word and both flags are compared just after every edge, and the rejected word of a full-store collision must never surface.

// File: rtl/fifo_wrap_pkg.sv
package fifo_wrap_pkg;

  // Operation seen on one edge, after acceptance
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

  // Next index modulo depth, without relying on a power-of-two size
  function automatic int unsigned step_index(int unsigned idx, int unsigned depth);
    if (idx >= depth - 1) return 0;
    return idx + 1;
  endfunction

  // True when an index sits on the last entry
  function automatic bit at_last(int unsigned idx, int unsigned depth);
    return idx == depth - 1;
  endfunction

  // Index width that still works for depth 1
  function automatic int unsigned index_width(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/fifo_wrap_index.sv
module fifo_wrap_index
  import fifo_wrap_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int IDX_W = index_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             turn
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= IDX_W'(step_index(int'(idx_q), DEPTH));
    end
  end

  assign idx  = idx_q;
  assign turn = adv && at_last(int'(idx_q), DEPTH);

endmodule

// File: rtl/fifo_wrap_store.sv
module fifo_wrap_store
  import fifo_wrap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5,
  localparam int IDX_W = index_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_fire,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      cells[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (rd_fire) begin
      out_q <= cells[rd_idx];
    end
  end

  assign rd_data = out_q;

endmodule

// File: rtl/fifo_wrap_status.sv
module fifo_wrap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_turn,
  input  logic rd_turn,
  input  logic same_idx,
  output logic wrap,
  output logic full,
  output logic empty
);

  logic wrap_q;

  // The two turns cannot coincide: equal indices at the last entry mean
  // either full (write refused) or empty (read refused).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= 1'b0;
    end else if (wr_turn) begin
      wrap_q <= 1'b1;
    end else if (rd_turn) begin
      wrap_q <= 1'b0;
    end
  end

  assign wrap  = wrap_q;
  assign full  = same_idx &&  wrap_q;
  assign empty = same_idx && !wrap_q;

endmodule

// File: rtl/sync_fifo_wrap.sv
module sync_fifo_wrap
  import fifo_wrap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);

  localparam int IDX_W = index_width(DEPTH);

  // Named internal events
  logic             wr_fire;
  logic             rd_fire;
  logic             wr_turn;
  logic             rd_turn;
  logic             same_idx;
  logic             wrap;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  fifo_op_e         op;

  // A full store refuses writes even when a read shares the edge
  assign wr_fire  = wr_en && !full;
  assign rd_fire  = rd_en && !empty;
  assign op       = fifo_op_e'({rd_fire, wr_fire});
  assign same_idx = (wr_idx == rd_idx);

  fifo_wrap_index #(.DEPTH(DEPTH)) u_wr_index (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (op == OP_PUSH || op == OP_BOTH),
    .idx  (wr_idx),
    .turn (wr_turn)
  );

  fifo_wrap_index #(.DEPTH(DEPTH)) u_rd_index (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (op == OP_POP || op == OP_BOTH),
    .idx  (rd_idx),
    .turn (rd_turn)
  );

  fifo_wrap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_fire(wr_fire),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_fire(rd_fire),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  fifo_wrap_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_turn (wr_turn),
    .rd_turn (rd_turn),
    .same_idx(same_idx),
    .wrap    (wrap),
    .full    (full),
    .empty   (empty)
  );

endmodule

// File: rtl/fifo_wrap_chk.sv
module fifo_wrap_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic              wrap,
  input logic              wr_turn,
  input logic              rd_turn,
  input logic [DATA_W-1:0] rd_data
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> full);

  a_r5_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en |=> empty && $stable(rd_data));

  a_r4_first_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty && wr_en |=> !empty);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r9_full_collision: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && rd_en |=> !full && !empty);

  a_r10_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_turn |=> wrap);

  a_r10_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_turn |=> !wrap);

endmodule

bind sync_fifo_wrap fifo_wrap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .full   (full),
  .empty  (empty),
  .wrap   (wrap),
  .wr_turn(wr_turn),
  .rd_turn(rd_turn),
  .rd_data(rd_data)
);

// File: tb/sync_fifo_wrap_tb_top.sv
module sync_fifo_wrap_tb_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              full;
  logic              empty;

  sync_fifo_wrap #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .full   (full),
    .empty  (empty)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // Scoreboard state
  logic [DATA_W-1:0] exp_q [$];
  int                held = 0;
  bit                pend_rd = 1'b0;
  bit                exp_full = 1'b0;
  bit                exp_empty = 1'b1;
  logic [DATA_W-1:0] last_out = '0;
  bit                mon_on = 1'b0;
  string             cur_tag = "R4";

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of requests and updates the model
  task automatic step(bit w, bit r, logic [DATA_W-1:0] d);
    bit w_ok;
    bit r_ok;
    @(negedge clk);
    wr_en   = w;
    rd_en   = r;
    wr_data = d;
    w_ok = w && (held < DEPTH);
    r_ok = r && (held > 0);
    if (w_ok) exp_q.push_back(d);
    pend_rd = r_ok;
    held = held + int'(w_ok) - int'(r_ok);
    exp_full  = (held == DEPTH);
    exp_empty = (held == 0);
  endtask

  // Monitor: pops the scoreboard when a read was accepted
  always @(posedge clk) begin
    if (mon_on) begin
      bit took;
      took = pend_rd;
      #2;
      if (took) begin
        last_out = exp_q.pop_front();
      end
      chk(rd_data == last_out, cur_tag, 32'(rd_data), 32'(last_out));
      chk(full == exp_full, "R8", 32'(full), 32'(exp_full));
      chk(empty == exp_empty, "R7", 32'(empty), 32'(exp_empty));
    end
  end

  initial begin
    #(2_000_000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;

    // R4: reset state
    #12;
    chk(empty == 1'b1, "R4", 32'(empty), 1);
    chk(full == 1'b0, "R4", 32'(full), 0);
    chk(rd_data == '0, "R4", 32'(rd_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R11: read while empty is ignored
    cur_tag = "R11";
    step(0, 1, 8'h00);
    step(0, 1, 8'h00);

    // R2, R5: back-to-back writes up to full, output untouched
    cur_tag = "R5";
    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'(8'h10 + i));
    step(0, 0, 8'h00);
    chk(full == 1'b1, "R2", 32'(full), 1);

    // R3: writes while full are dropped
    cur_tag = "R3";
    step(1, 0, 8'hEE);
    step(1, 0, 8'hEF);

    // R1, R6, R7: drain in order until empty
    cur_tag = "R1";
    for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00);
    step(0, 0, 8'h00);
    chk(empty == 1'b1, "R7", 32'(empty), 1);
    cur_tag = "R11";
    step(0, 1, 8'h00);

    // Empty collision: only the write takes effect
    cur_tag = "R6";
    step(1, 1, 8'h21);
    step(0, 1, 8'h00);

    // R9: full collision
    cur_tag = "R9";
    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'(8'h30 + i));
    step(1, 1, 8'hBB);
    step(0, 0, 8'h00);
    chk(full == 1'b0 && empty == 1'b0, "R9", {30'd0, full, empty}, 0);

    // R12: part-filled collisions keep the count
    cur_tag = "R12";
    for (int i = 0; i < 12; i++) step(1, 1, 8'(8'h50 + i));
    step(0, 0, 8'h00);
    chk(held == DEPTH - 1 && full == 1'b0, "R12", 32'(full), 0);
    for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00);

    // R10: random traffic rolling the indices over many times
    cur_tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr[15:8]);
    end
    cur_tag = "R1";
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 8'h00);
    step(0, 0, 8'h00);
    chk(empty == 1'b1 && exp_q.size() == 0, "R7", 32'(empty), 1);

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule